// File: doc/BRIEF.md
# Framed Serial DAC Input Register

This block is the digital front end of a voltage-output digital-to-analog converter. A host writes a code over a three-wire serial link: an active-low chip select that frames each transfer, a serial clock, and a data line. While the frame is open, one data bit enters a 16-bit shift register on each rising serial clock edge, most significant bit first. When chip select returns high, a complete word is copied into the converter's data latch. The latch output is the code the analog section converts.

A parameter sets the converter resolution to 16, 14 or 12 bits. A shorter code sits in the upper bits of the 16-bit word, and the host pads it with trailing don't-care bits. A second parameter sets the code loaded by power-on reset and by the active-low clear input. That code is either zero scale or midscale. Clear acts on the latch at once, without waiting for a clock. A frame that ends with fewer than 16 serial clock edges is reported on a status pulse and is discarded.

The serial inputs are sampled by the system clock `clk`. The serial clock therefore runs well below the `clk` rate.

Top module: `dac_serial_front`

## Requirements
- R1: While `rst_n` is low at a `clk` edge, `dac_code` is set to the clear code, and `update` and `short_frame` are set to 0.
- R2: A frame of exactly 16 rising `sclk` edges with `cs_n` low loads the 16 bits, first bit as most significant, into the latch. On the second `clk` edge after `cs_n` is sampled high, `dac_code` takes the new value and `update` is 1. `update` is 1 for exactly one cycle.
- R3: Rising `sclk` edges while `cs_n` is high neither shift data nor count toward the next frame.
- R4: In a frame with more than 16 rising `sclk` edges, only the last 16 bits shifted in are loaded.
- R5: A frame that closes with fewer than 16 rising `sclk` edges, including zero, leaves `dac_code` unchanged and gives no `update`. `short_frame` is 1 for exactly one cycle, with the same timing that `update` has in R2.
- R6: `dac_code` is RES_W bits wide and equals bits [15:16-RES_W] of the loaded word. The trailing don't-care bits have no effect.
- R7: When `clr_n` is low, `dac_code` equals the clear code without any `clk` edge, and `update` is 0.
- R8: Clear has priority over a frame that closes while `clr_n` is low: `dac_code` stays at the clear code and no `update` occurs. After `clr_n` returns high, the next complete frame loads normally.
- R9: The clear code is all zeros when MID_CLEAR is 0. When MID_CLEAR is 1, only the most significant bit of `dac_code` is set (0x800 at 12 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial inputs |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| clr_n | input | 1 | Asynchronous active-low clear of the DAC latch |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data shifts on its rising edge |
| din | input | 1 | Serial data, most significant bit first |
| dac_code | output | RES_W | Latched converter code |
| update | output | 1 | One-cycle pulse when a complete frame loads the latch |
| short_frame | output | 1 | One-cycle pulse when a frame closes with fewer than 16 edges |

## Verification
Two instances are driven from the same serial pins. One is at full 16-bit width with a zero-scale clear. The other is at 12 bits with a midscale clear. Together they show whether the upper-bit selection and the clear-code choice are wired correctly. Walking-one words catch swapped or shifted bit positions. A sweep of 1024 spread codes catches mixing between neighbouring bits. A pair of words that differ only in their low four bits shows that the 12-bit instance ignores the pad bits.

Frames of 15 and zero edges show that the latch holds its value. Frames of 20 and 24 edges show that only the last 16 bits count. Clock edges sent while `cs_n` is high, followed by an empty frame, show whether such edges were counted. Clear is checked between clock edges for its asynchronous effect, and again across a frame close to confirm its priority.

// File: rtl/dac_in_pkg.sv
// Package: shared helpers for the serial DAC input register.
// Assumes resolutions of at most 32 bits.
package dac_in_pkg;

    // Code loaded by reset and by clear: zero scale, or midscale (MSB only).
    function automatic logic [31:0] clear_code(input int unsigned res_w, input bit mid);
        return mid ? (32'd1 << (res_w - 1)) : 32'd0;
    endfunction

endpackage

// File: rtl/dac_in_sync.sv
// Module: dac_in_sync
// Samples the serial pins on clk and detects serial clock and chip select edges.
// Assumes sclk and cs_n each hold every level for at least two clk cycles.
module dac_in_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    output logic cs_high,
    output logic cs_rise,
    output logic sclk_rise,
    output logic din_s
);
    logic cs_q1, cs_q2, sclk_q1, sclk_q2;

    // Two-stage sampling of the framing pins and one stage for data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q1   <= 1'b1;
            cs_q2   <= 1'b1;
            sclk_q1 <= 1'b0;
            sclk_q2 <= 1'b0;
            din_s   <= 1'b0;
        end else begin
            cs_q1   <= cs_n;
            cs_q2   <= cs_q1;
            sclk_q1 <= sclk;
            sclk_q2 <= sclk_q1;
            din_s   <= din;
        end
    end

    // Edge decode on the sampled levels.
    always_comb begin
        cs_high   = cs_q1;
        cs_rise   = cs_q1 & ~cs_q2;
        sclk_rise = sclk_q1 & ~sclk_q2;
    end
endmodule

// File: rtl/dac_in_shift.sv
// Module: dac_in_shift
// Shift register plus saturating edge counter for one frame.
// Flags a complete frame (frame_ok, same cycle) or a short one (short_frame, registered).
// Assumes the edge strobes come from dac_in_sync.
module dac_in_shift #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_high,
    input  logic              cs_rise,
    input  logic              sclk_rise,
    input  logic              din_s,
    output logic [WORD_W-1:0] word,
    output logic              frame_ok,
    output logic              short_frame
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    logic [CNT_W-1:0] cnt;

    // Shift one bit in, MSB first, on each serial clock edge inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= '0;
        else if (sclk_rise && !cs_high)
            word <= {word[WORD_W-2:0], din_s};
    end

    // Count edges in the open frame; saturate at the word length, clear while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cs_high)
            cnt <= '0;
        else if (sclk_rise && cnt != FULL)
            cnt <= cnt + 1'b1;
    end

    // Frame close decode: complete frames load, short ones only report.
    always_comb frame_ok = cs_rise && (cnt == FULL);

    // Registered short-frame pulse, aligned with the latch update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            short_frame <= 1'b0;
        else
            short_frame <= cs_rise && (cnt != FULL);
    end

    // R4: the edge counter never passes the word length.
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);

    // R3: while idle, the counter is back at zero one cycle later.
    a_r3_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cs_high |=> (cnt == '0));
endmodule

// File: rtl/dac_in_latch.sv
// Module: dac_in_latch
// DAC data latch: loads the upper RES_W bits of a complete word.
// Cleared asynchronously by clr_n and synchronously by rst_n.
// Assumes load is a single-cycle strobe.
module dac_in_latch #(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned RES_W     = 16,
    parameter bit          MID_CLEAR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic [RES_W-1:0]  dac_code,
    output logic              update
);
    localparam logic [RES_W-1:0] CLR_CODE = RES_W'(dac_in_pkg::clear_code(RES_W, MID_CLEAR));

    // Latch the code; clear wins over everything, then reset, then a load.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            dac_code <= CLR_CODE;
            update   <= 1'b0;
        end else if (!rst_n) begin
            dac_code <= CLR_CODE;
            update   <= 1'b0;
        end else begin
            update <= load;
            if (load)
                dac_code <= word[WORD_W-1 -: RES_W];
        end
    end

    // R2: without an update and with clear inactive, the code holds.
    a_r2_hold_without_update: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && $past(clr_n) && !update) |-> $stable(dac_code));

    // R7 / R9: while clear is held, the latch shows the clear code.
    a_r7_clear_code: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (dac_code == CLR_CODE));

    // R1: leaving reset, the latch holds the clear code.
    a_r1_reset_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_code == CLR_CODE));
endmodule

// File: rtl/dac_serial_front.sv
// Module: dac_serial_front
// Top of the serial DAC input register: sampler, shift register and data latch.
// Assumes the serial clock runs at most at a quarter of the clk rate.
module dac_serial_front #(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned RES_W     = 16,
    parameter bit          MID_CLEAR = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    output logic [RES_W-1:0] dac_code,
    output logic             update,
    output logic             short_frame
);
    logic              cs_high, cs_rise, sclk_rise, din_s, frame_ok;
    logic [WORD_W-1:0] word;

    dac_in_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .cs_high(cs_high), .cs_rise(cs_rise), .sclk_rise(sclk_rise), .din_s(din_s)
    );

    dac_in_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_high(cs_high), .cs_rise(cs_rise),
        .sclk_rise(sclk_rise), .din_s(din_s), .word(word),
        .frame_ok(frame_ok), .short_frame(short_frame)
    );

    dac_in_latch #(.WORD_W(WORD_W), .RES_W(RES_W), .MID_CLEAR(MID_CLEAR)) u_latch (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load(frame_ok), .word(word),
        .dac_code(dac_code), .update(update)
    );

    // R2: an update lasts exactly one cycle.
    a_r2_update_single: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> !update);

    // R5: a short frame never coincides with an update.
    a_r5_short_excl: assert property (@(posedge clk) disable iff (!rst_n)
        short_frame |-> !update);

    // R8: no update is reported while clear is held.
    a_r8_clear_blocks_update: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> !update);
endmodule

// File: tb/dac_serial_front_tb.sv
// Bench for dac_serial_front: a 16-bit zero-clear instance and a 12-bit midscale instance.
// Both share the same pins. Inputs change on falling clk edges; outputs are checked there too.
module dac_serial_front_tb;
    logic        clk = 1'b0;
    logic        rst_n, clr_n, cs_n, sclk, din;
    logic [15:0] code_a;
    logic [11:0] code_b;
    logic        upd_a, upd_b, sh_a, sh_b;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;
    logic [15:0] exp_word;

    always #4 clk = ~clk;

    dac_serial_front #(.RES_W(16), .MID_CLEAR(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dac_code(code_a), .update(upd_a), .short_frame(sh_a)
    );

    dac_serial_front #(.RES_W(12), .MID_CLEAR(1'b1)) u_dut_mid (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dac_code(code_b), .update(upd_b), .short_frame(sh_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Opens a frame and shifts the low n bits of v, most significant first.
    task automatic shift_bits(input logic [31:0] v, input int n);
        cs_n = 1'b0;
        wait_neg(2);
        for (int i = n - 1; i >= 0; i--) begin
            din  = v[i];
            sclk = 1'b0;
            wait_neg(2);
            sclk = 1'b1;
            wait_neg(2);
        end
        sclk = 1'b0;
        wait_neg(2);
    endtask

    // Closes the frame and waits until the registered result is visible.
    task automatic close_frame();
        cs_n = 1'b1;
        wait_neg(2);
    endtask

    // Complete frame: checks the loaded codes on both instances and the update pulse.
    task automatic full_frame(input logic [15:0] w, input string req);
        shift_bits({16'h0, w}, 16);
        close_frame();
        check({req, " code16"}, code_a, w);
        check({req, " code12"}, code_b, w[15:4]);
        check({req, " update"}, {upd_a, upd_b}, 2'b11);
        wait_neg(1);
        check("R2 update one cycle", {upd_a, upd_b}, 2'b00);
        exp_word = w;
    endtask

    // Short frame: the latch keeps exp_word and short_frame pulses once.
    task automatic short_check(input string req);
        check({req, " short pulse"}, {sh_a, sh_b}, 2'b11);
        check({req, " no update"}, {upd_a, upd_b}, 2'b00);
        check({req, " code16 held"}, code_a, exp_word);
        check({req, " code12 held"}, code_b, exp_word[15:4]);
        wait_neg(1);
        check({req, " short one cycle"}, {sh_a, sh_b}, 2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; clr_n = 1'b1; cs_n = 1'b1; sclk = 1'b0; din = 1'b0;
        wait_neg(4);
        // R1 / R9: reset state and clear codes.
        check("R1 R9 reset code16 zero scale", code_a, 16'h0000);
        check("R1 R9 reset code12 midscale", code_b, 12'h800);
        check("R1 reset flags", {upd_a, upd_b, sh_a, sh_b}, 4'b0000);
        rst_n = 1'b1;
        exp_word = 16'h8000;
        wait_neg(2);

        // R2 / R6: walking ones.
        for (int b = 0; b < 16; b++)
            full_frame(16'(1) << b, "R2 R6 walking one");

        // R2 / R6: sweep of spread codes.
        for (int i = 0; i < 1024; i++)
            full_frame(16'((i * 40503 + (i >> 3)) & 16'hFFFF), "R2 R6 sweep");

        // R6: pad bits are ignored at 12 bits.
        full_frame(16'hABC5, "R6 pad a");
        full_frame(16'hABCA, "R6 pad b");
        check("R6 pad bits ignored code12", code_b, 12'hABC);

        // R4: longer frames keep the last 16 bits.
        shift_bits(32'h000F_1234, 20);
        close_frame();
        check("R4 20 edges code16", code_a, 16'h1234);
        check("R4 20 edges code12", code_b, 12'h123);
        exp_word = 16'h1234;
        wait_neg(1);
        shift_bits(32'h00A5_C3E7, 24);
        close_frame();
        check("R4 24 edges code16", code_a, 16'hC3E7);
        check("R4 24 edges update", {upd_a, upd_b}, 2'b11);
        exp_word = 16'hC3E7;
        wait_neg(1);

        // R5: short frames are dropped.
        shift_bits(32'h0000_5555, 15);
        close_frame();
        short_check("R5 15 edges");
        shift_bits(32'h0, 0);
        close_frame();
        short_check("R5 zero edges");

        // R3: edges while idle are not counted.
        din = 1'b1;
        for (int i = 0; i < 16; i++) begin
            sclk = 1'b1; wait_neg(2);
            sclk = 1'b0; wait_neg(2);
        end
        shift_bits(32'h0, 0);
        close_frame();
        short_check("R3 idle edges ignored");

        // R7: asynchronous clear between clock edges.
        full_frame(16'h7F3C, "R7 preload");
        #1 clr_n = 1'b0;
        #1;
        check("R7 async clear code16", code_a, 16'h0000);
        check("R7 R9 async clear code12", code_b, 12'h800);
        wait_neg(3);
        check("R7 clear no update", {upd_a, upd_b}, 2'b00);
        clr_n = 1'b1;
        wait_neg(1);
        check("R7 held after release", code_a, 16'h0000);

        // R8: clear wins over a frame closing under it, then a fresh frame loads.
        shift_bits(32'h0000_9A6D, 16);
        clr_n = 1'b0;
        wait_neg(1);
        cs_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            wait_neg(1);
            check("R8 no update under clear", {upd_a, upd_b}, 2'b00);
        end
        check("R8 code16 stays clear", code_a, 16'h0000);
        check("R8 code12 stays clear", code_b, 12'h800);
        clr_n = 1'b1;
        wait_neg(2);
        full_frame(16'h4E21, "R8 load after release");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule